// File: doc/BRIEF.md
# Keyed Countdown Watchdog

This block is a watchdog timer on a simple 32-bit register bus. It counts strobes of a slow tick, nominally 32.768 kHz, supplied by the surrounding clock logic. Software sets a timeout in units of 512 ticks, so 64 units make one second. It enables counting and then has to keep reloading the counter. If the count runs out, the block raises a fixed-length reset pulse. In interrupt mode it raises an interrupt instead. In dual mode it raises the interrupt first and issues the reset only on a second expiry with no reload in between.

Every write that changes state is checked against a constant held in the written word. A control write whose key field is wrong changes nothing. A reload or forced-reset write whose word is not the exact magic value also changes nothing. A dedicated register issues a reset pulse at once, whether counting is enabled or not. A second reset output can drive an external pin, with its active level chosen by software.

Top module: `wdt_keyed`

## Requirements
- R1: After power-on reset the enable bit reads 0 (auto-start strap off), the whole control register reads 0, the length field holds its maximum (length register reads 0x0000FFE0), `sys_rst_o` and `irq_o` are low and `ext_rst_o` rests high (active-low idle).
- R2: A write to offset 0x00 takes effect only when bits [31:24] equal 0x22. Bit 0 is enable, bit 1 is the external polarity (1 = active high), bit 2 is the external output enable, bit 3 is interrupt mode, bit 4 is auto-start and bit 6 is dual mode. A read returns these bits with every other bit as 0.
- R3: A write to offset 0x04 takes effect only when bits [4:0] equal 0x08. The timeout in units sits in bits [15:5]. A read returns the stored value in bits [15:5], with every other bit as 0.
- R4: Writing exactly 0x00001971 to offset 0x08 restarts the countdown from the programmed length and clears a pending interrupt. Any other value at 0x08 has no effect, and offset 0x08 reads as 0.
- R5: Writing exactly 0x00001209 to offset 0x14 starts a reset pulse on the next clock, whether or not counting is enabled. Any other value at 0x14 has no effect.
- R6: While enabled, expiry occurs on the tick that completes length × 512 ticks after a restart or enable. A length of 0 behaves as 1. Cycles without a tick strobe do not count.
- R7: On expiry with interrupt mode off, `sys_rst_o` is high for exactly 16 clock cycles and the counter reloads.
- R8: On expiry with interrupt mode on and dual mode off, `irq_o` goes high and stays high until a valid restart, and no reset pulse is produced.
- R9: In dual mode with interrupt mode on, the first expiry raises `irq_o` and a second expiry without a restart produces the reset pulse.
- R10: Clearing the enable bit with a valid key freezes the countdown. Re-enabling resumes it from the frozen position.
- R11: When bit 2 of the control register is set, `ext_rst_o` drives the level given by bit 1 during a reset pulse and its inverse otherwise. When bit 2 is clear, it holds the inverse of bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| tick_i | input | 1 | One-cycle strobe per slow-clock tick |
| addr_i | input | 8 | Byte offset of the register accessed |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| wdata_i | input | 32 | Write data including key field |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| sys_rst_o | output | 1 | Active-high system reset pulse |
| ext_rst_o | output | 1 | External reset pin, software-selected polarity |
| irq_o | output | 1 | Expiry interrupt, level |

## Verification
The bench times expiry to the exact cycle, so an off-by-one prescaler that fires a unit early or late fails the boundary check. It writes near-miss keys and values, so a design that decodes only part of the key field or of a magic word would change state. It freezes the countdown by disabling and by holding the tick low, so a design that restarts rather than resumes, or that counts bus clocks, misses the expected expiry cycle. It walks the interrupt and dual modes, so a design that resets on the first expiry in dual mode, or that fails to hold the interrupt, shows up at the outputs.

// File: rtl/wdt_keyed.sv
module wdt_keyed #(
  parameter int ADDR_W     = 8,
  parameter int LEN_W      = 11,
  parameter int UNIT_TICKS = 512,
  parameter int PULSE_CYC  = 16,
  parameter bit AUTO_START = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              sys_rst_o,
  output logic              ext_rst_o,
  output logic              irq_o
);
  localparam int PRE_W = (UNIT_TICKS > 1) ? $clog2(UNIT_TICKS) : 1;
  localparam int PLS_W = $clog2(PULSE_CYC + 1);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] A_KICK = ADDR_W'('h08);
  localparam logic [ADDR_W-1:0] A_SWR  = ADDR_W'('h14);
  localparam logic [7:0]  MODE_KEY = 8'h22;
  localparam logic [4:0]  LEN_KEY  = 5'h08;
  localparam logic [31:0] KICK_VAL = 32'h0000_1971;
  localparam logic [31:0] SWR_VAL  = 32'h0000_1209;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(UNIT_TICKS - 1);

  logic en_q, pol_q, ext_q, irq_en_q, auto_q, dual_q, irq_q;
  logic [LEN_W-1:0] len_q, cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic [PLS_W-1:0] pls_q;
  logic sel_mode, sel_len, mode_ok, len_ok, kick, swr_hit;
  logic step, unit_end, expire, fire;

  assign sel_mode = wr_en_i && (addr_i == A_MODE);
  assign sel_len  = wr_en_i && (addr_i == A_LEN);
  assign mode_ok  = sel_mode && (wdata_i[31:24] == MODE_KEY);
  assign len_ok   = sel_len && (wdata_i[4:0] == LEN_KEY);
  assign kick     = wr_en_i && (addr_i == A_KICK) && (wdata_i == KICK_VAL);
  assign swr_hit  = wr_en_i && (addr_i == A_SWR) && (wdata_i == SWR_VAL);

  assign step     = en_q && tick_i && !kick;
  assign unit_end = step && (pre_q == PRE_LAST);
  assign expire   = unit_end && (cnt_q <= LEN_W'(1));
  assign fire     = swr_hit || (expire && (!irq_en_q || (dual_q && irq_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q     <= AUTO_START;
      auto_q   <= AUTO_START;
      pol_q    <= 1'b0;
      ext_q    <= 1'b0;
      irq_en_q <= 1'b0;
      dual_q   <= 1'b0;
    end else if (mode_ok) begin
      en_q     <= wdata_i[0];
      pol_q    <= wdata_i[1];
      ext_q    <= wdata_i[2];
      irq_en_q <= wdata_i[3];
      auto_q   <= wdata_i[4];
      dual_q   <= wdata_i[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      len_q <= '1;
    else if (len_ok) len_q <= wdata_i[LEN_W+4:5];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      pre_q <= '0;
    end else if (kick) begin
      cnt_q <= len_q;
      pre_q <= '0;
    end else if (step) begin
      if (unit_end) begin
        pre_q <= '0;
        cnt_q <= expire ? len_q : cnt_q - LEN_W'(1);
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    irq_q <= 1'b0;
    else if (kick)                 irq_q <= 1'b0;
    else if (expire && irq_en_q)   irq_q <= !(dual_q && irq_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            pls_q <= '0;
    else if (fire)         pls_q <= PLS_W'(PULSE_CYC);
    else if (pls_q != '0)  pls_q <= pls_q - PLS_W'(1);
  end

  assign sys_rst_o = (pls_q != '0);
  assign ext_rst_o = (ext_q && sys_rst_o) ? pol_q : !pol_q;
  assign irq_o     = irq_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_MODE)
      rdata_o = {25'd0, dual_q, 1'b0, auto_q, irq_en_q, ext_q, pol_q, en_q};
    else if (addr_i == A_LEN)
      rdata_o[LEN_W+4:5] = len_q;
  end

  assert_badkey_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mode && wdata_i[31:24] != MODE_KEY) |=>
      $stable({en_q, pol_q, ext_q, irq_en_q, auto_q, dual_q}));

  assert_badkey_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_len && wdata_i[4:0] != LEN_KEY) |=> $stable(len_q));

  assert_kick_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == $past(len_q)) && !irq_o);

  assert_swr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    swr_hit |=> sys_rst_o);

  assert_irq_needs_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(irq_en_q));

  assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !kick) |=> ($stable(cnt_q) && $stable(pre_q)));
endmodule

// File: tb/wdt_keyed_tb_top.sv
module wdt_keyed_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b1;
  logic [7:0]  addr_i = '0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        sys_rst_o, ext_rst_o, irq_o;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  wdt_keyed dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .addr_i(addr_i),
    .wr_en_i(wr_en_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .sys_rst_o(sys_rst_o), .ext_rst_o(ext_rst_o), .irq_o(irq_o)
  );

  // addr, wdata, read addr, expected read data
  localparam logic [79:0] VEC [0:8] = '{
    {8'h00, 32'h2200005E, 8'h00, 32'h0000005E},   // R2 valid key
    {8'h00, 32'h2100005F, 8'h00, 32'h0000005E},   // R2 wrong key
    {8'h00, 32'h22000000, 8'h00, 32'h00000000},   // R2
    {8'h04, 32'h00000148, 8'h04, 32'h00000140},   // R3 valid key
    {8'h04, 32'h000003E9, 8'h04, 32'h00000140},   // R3 wrong key
    {8'h04, 32'hFFFFFFE8, 8'h04, 32'h0000FFE0},   // R3 upper bits dropped
    {8'h08, 32'h00001234, 8'h08, 32'h00000000},   // R4 reads zero
    {8'h00, 32'h2200FFFF, 8'h00, 32'h0000005F},   // R2 reserved bits read 0
    {8'h00, 32'h22000000, 8'h00, 32'h00000000}    // R2
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en_i = 1'b0; wdata_i = '0; addr_i = '0;
  endtask

  task automatic waitn(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr_i = a;
    #1 d = rdata_o;
    addr_i = '0;
  endtask

  task automatic pulse_len(output int n);
    n = 0;
    while (sys_rst_o && n < 100) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic idle_off();
    wr(8'h00, 32'h22000000);
    waitn(20);
  endtask

  task automatic arm(input logic [31:0] mode, input logic [31:0] lenw);
    wr(8'h00, 32'h22000000 | (mode & 32'hFFFF_FFFE));
    wr(8'h04, lenw);
    wr(8'h08, 32'h00001971);
    wr(8'h00, 32'h22000001 | mode);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    int seen;
    waitn(3);
    rst_n = 1'b1;
    waitn(1);

    rd(8'h00, d); chk("R1 mode", d, 32'h0);
    rd(8'h04, d); chk("R1 length", d, 32'h0000FFE0);
    chk("R1 sys_rst", {31'd0, sys_rst_o}, 32'd0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    chk("R1 ext idle", {31'd0, ext_rst_o}, 32'd1);

    for (int i = 0; i < 9; i++) begin
      wr(VEC[i][79:72], VEC[i][71:40]);
      rd(VEC[i][39:32], d);
      chk($sformatf("R2/R3/R4 vector %0d", i), d, VEC[i][31:0]);
    end

    // R5 wrong value then correct value
    wr(8'h14, 32'h00001208);
    seen = 0;
    for (int i = 0; i < 5; i++) begin
      if (sys_rst_o) seen++;
      waitn(1);
    end
    chk("R5 wrong value ignored", seen, 0);
    wr(8'h14, 32'h00001209);
    pulse_len(n);
    chk("R5 forced pulse length", n, 16);
    waitn(5);

    // R11 external pin
    wr(8'h00, 32'h22000004);
    chk("R11 ext idle low-pol", {31'd0, ext_rst_o}, 32'd1);
    wr(8'h14, 32'h00001209);
    chk("R11 ext active low", {31'd0, ext_rst_o}, 32'd0);
    waitn(20);
    wr(8'h00, 32'h22000006);
    chk("R11 ext idle high-pol", {31'd0, ext_rst_o}, 32'd0);
    wr(8'h14, 32'h00001209);
    chk("R11 ext active high", {31'd0, ext_rst_o}, 32'd1);
    waitn(20);
    wr(8'h00, 32'h22000002);
    wr(8'h14, 32'h00001209);
    chk("R11 ext disabled holds", {31'd0, ext_rst_o}, 32'd0);
    waitn(20);
    idle_off();

    // R6/R7 one unit
    arm(32'h0, 32'h00000028);
    waitn(511); chk("R6 len1 not early", {31'd0, sys_rst_o}, 32'd0);
    waitn(1);   chk("R6 len1 expiry", {31'd0, sys_rst_o}, 32'd1);
    pulse_len(n); chk("R7 expiry pulse length", n, 16);
    idle_off();

    // R6 two units
    arm(32'h0, 32'h00000048);
    waitn(1023); chk("R6 len2 not early", {31'd0, sys_rst_o}, 32'd0);
    waitn(1);    chk("R6 len2 expiry", {31'd0, sys_rst_o}, 32'd1);
    idle_off();

    // R6 zero length acts as one
    arm(32'h0, 32'h00000008);
    waitn(511); chk("R6 len0 not early", {31'd0, sys_rst_o}, 32'd0);
    waitn(1);   chk("R6 len0 expiry", {31'd0, sys_rst_o}, 32'd1);
    idle_off();

    // R6 no counting without tick
    tick_i = 1'b0;
    arm(32'h0, 32'h00000028);
    waitn(1000); chk("R6 no tick no count", {31'd0, sys_rst_o}, 32'd0);
    tick_i = 1'b1;
    waitn(511); chk("R6 tick resume not early", {31'd0, sys_rst_o}, 32'd0);
    waitn(1);   chk("R6 tick resume expiry", {31'd0, sys_rst_o}, 32'd1);
    idle_off();

    // R4 wrong restart value ignored
    arm(32'h0, 32'h00000028);
    waitn(299);
    wr(8'h08, 32'h00001970);
    waitn(211); chk("R4 bad restart not early", {31'd0, sys_rst_o}, 32'd0);
    waitn(1);   chk("R4 bad restart ignored", {31'd0, sys_rst_o}, 32'd1);
    idle_off();

    // R4 valid restart reloads
    arm(32'h0, 32'h00000028);
    waitn(299);
    wr(8'h08, 32'h00001971);
    waitn(211); chk("R4 restart postpones", {31'd0, sys_rst_o}, 32'd0);
    waitn(300); chk("R4 restart not early", {31'd0, sys_rst_o}, 32'd0);
    waitn(1);   chk("R4 restart expiry", {31'd0, sys_rst_o}, 32'd1);
    idle_off();

    // R10 freeze while disabled
    arm(32'h0, 32'h00000028);
    waitn(299);
    wr(8'h00, 32'h22000000);
    waitn(1000); chk("R10 frozen", {31'd0, sys_rst_o}, 32'd0);
    wr(8'h00, 32'h22000001);
    waitn(211); chk("R10 resume not early", {31'd0, sys_rst_o}, 32'd0);
    waitn(1);   chk("R10 resume expiry", {31'd0, sys_rst_o}, 32'd1);
    idle_off();

    // R8 interrupt mode
    arm(32'h00000008, 32'h00000028);
    waitn(511); chk("R8 irq not early", {31'd0, irq_o}, 32'd0);
    waitn(1);   chk("R8 irq raised", {31'd0, irq_o}, 32'd1);
    seen = 0;
    for (int i = 0; i < 1100; i++) begin
      if (sys_rst_o) seen++;
      waitn(1);
    end
    chk("R8 no reset in irq mode", seen, 0);
    chk("R8 irq held", {31'd0, irq_o}, 32'd1);
    wr(8'h08, 32'h00001971);
    chk("R4 restart clears irq", {31'd0, irq_o}, 32'd0);
    idle_off();

    // R9 dual mode
    arm(32'h00000048, 32'h00000028);
    waitn(512);
    chk("R9 first expiry irq", {31'd0, irq_o}, 32'd1);
    chk("R9 first expiry no reset", {31'd0, sys_rst_o}, 32'd0);
    waitn(511); chk("R9 second not early", {31'd0, sys_rst_o}, 32'd0);
    waitn(1);   chk("R9 second expiry reset", {31'd0, sys_rst_o}, 32'd1);
    pulse_len(n); chk("R9 pulse length", n, 16);
    idle_off();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule